// File: doc/BRIEF.md
# PMIC Trigger and Warm Reset Sequencer

This block turns three high-level commands (power the processor on, power it off, warm-reset it) into the handshakes a power-management IC expects on two active-low control lines: a power key and a reset input. Start holds the power key low. Stop holds both the power key and the reset input low. Either one keeps the lines held until the processor power-good signal reaches the requested level or a response window closes. Warm reset drives a reset pulse of fixed width on the reset input. It then watches for the processor's reset-asserted indication. If that indication never arrives, the block asks for a cold reset.

The block checks two conditions before it drives anything. If the processor is already in the requested power state, the command succeeds at once and no line moves. If the reset input line does not read high, which means the PMIC is not pulling it up, a start or stop fails without driving any line. All timing counts a clock-enable tick supplied from outside, so the window and the pulse width are parameters in ticks. The three asynchronous inputs pass through a two-flop synchronizer.

Top module: `pmic_seq`

## Requirements
- R1: While reset is held, both control lines are released high and busy, done, ok and coldReq are all low.
- R2: A start command received while power-good already reads high, or a stop command received while it reads low, ends with done and ok=1 and never pulls either line low.
- R3: The command code is cmdOp: 2'b01 is start, 2'b10 is stop and 2'b11 is warm reset. Start pulls the power key low and leaves the reset input high. Stop pulls both lines low. Neither line is pulled low while the block is idle.
- R4: If the reset input line reads low when a start or stop command is checked, the command ends with done and ok=0 and neither line is pulled low.
- R5: During a start or stop, power-good is sampled only at ticks. The lines are held until a tick finds power-good at the requested level (ok=1) or until RESP_TICKS ticks pass without it (ok=0). Both lines are released in the same cycle as done, and done appears in the cycle that follows the deciding tick.
- R6: A warm reset waits for a tick, pulls the reset input low for exactly PULSE_TICKS tick periods and then releases it. The power key stays high throughout.
- R7: After the warm-reset pulse, a reset-asserted indication within RESP_TICKS ticks ends the command with ok=1. Without it, the command ends with ok=0 and coldReq pulses for one cycle together with done.
- R8: Busy rises in the cycle after a command is accepted and stays high until done. A command presented while busy is dropped. A command with code 2'b00 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time-base enable, one cycle per tick |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 2 | Command code (01 start, 10 stop, 11 warm reset) |
| cpuPwrGoodIn | input | 1 | Processor power-good, asynchronous |
| cpuRstSeenIn | input | 1 | Processor reset-asserted indication, asynchronous |
| rstLineSenseIn | input | 1 | Readback of the PMIC reset input line, asynchronous |
| pmicKeyN | output | 1 | Active-low power key to the PMIC |
| pmicRstN | output | 1 | Active-low reset input to the PMIC |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last command, valid with done |
| coldReq | output | 1 | One-cycle cold-reset request after a failed warm reset |

## Verification
The assertions check several invariants on every cycle. No line is held low while the block is idle. Both lines are high when done pulses. done and busy never overlap. A cold-reset request appears only as a single-cycle pulse that coincides with a failed completion. Other behaviours can only be shown by the bench's scenarios with an emulated PMIC: that the pulse width is exact, that done lines up with a tick, that the timeout cut-off falls where it should, that the already-on and already-off shortcuts leave both lines untouched, and that commands arriving while busy are dropped.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_WARM  = 2'b11
  } opCode_t;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic driveKey;    // pull power key low
    logic driveRst;    // pull reset input low
    logic releaseAll;  // release both lines high
    logic cntClear;    // zero the tick counter
    logic cntInc;      // advance the tick counter
    logic finish;      // command completes this cycle
    logic finishOk;    // result reported with finish
    logic coldReq;     // raise the cold-reset request
  } strobe_t;

endpackage

// File: rtl/pmic_seq_sync.sv
module pmic_seq_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pmic_seq_ctrl.sv
module pmic_seq_ctrl
  import pmic_seq_pkg::*;
#(
  parameter int RESP_TICKS = 350,
  parameter int PULSE_TICKS = 20,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cmdValid,
  input  opCode_t          cmdOp,
  input  logic             pwrGoodS,
  input  logic             rstSeenS,
  input  logic             lineSenseS,
  input  logic [CNT_W-1:0] cntVal,
  output strobe_t          stb,
  output logic             busy
);

  localparam logic [CNT_W-1:0] RESP_LAST  = CNT_W'(RESP_TICKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_HOLD, ST_PULSE, ST_WAITRST
  } state_t;

  state_t  state, nxt;
  opCode_t opReg;
  logic    targetOn;

  assign targetOn = (opReg == OP_START);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_NONE;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && cmdValid && cmdOp != OP_NONE) opReg <= cmdOp;
    end
  end

  always_comb begin
    stb = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && cmdOp != OP_NONE) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (opReg == OP_WARM) begin
          // align the pulse start to a tick so its width is exact
          if (tickEn) begin
            stb.driveRst = 1'b1;
            stb.cntClear = 1'b1;
            nxt          = ST_PULSE;
          end
        end else if (pwrGoodS == targetOn) begin
          stb.finish   = 1'b1;
          stb.finishOk = 1'b1;
          nxt          = ST_IDLE;
        end else if (!lineSenseS) begin
          stb.finish = 1'b1;
          nxt        = ST_IDLE;
        end else begin
          stb.driveKey = 1'b1;
          stb.driveRst = (opReg == OP_STOP);
          stb.cntClear = 1'b1;
          nxt          = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tickEn) begin
          if (pwrGoodS == targetOn) begin
            stb.releaseAll = 1'b1;
            stb.finish     = 1'b1;
            stb.finishOk   = 1'b1;
            nxt            = ST_IDLE;
          end else if (cntVal == RESP_LAST) begin
            stb.releaseAll = 1'b1;
            stb.finish     = 1'b1;
            nxt            = ST_IDLE;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_PULSE: begin
        if (tickEn) begin
          if (cntVal == PULSE_LAST) begin
            stb.releaseAll = 1'b1;
            stb.cntClear   = 1'b1;
            nxt            = ST_WAITRST;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_WAITRST: begin
        if (rstSeenS) begin
          stb.finish   = 1'b1;
          stb.finishOk = 1'b1;
          nxt          = ST_IDLE;
        end else if (tickEn) begin
          if (cntVal == RESP_LAST) begin
            stb.finish  = 1'b1;
            stb.coldReq = 1'b1;
            nxt         = ST_IDLE;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pmic_seq_dp.sv
module pmic_seq_dp
  import pmic_seq_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output logic [CNT_W-1:0] cntVal,
  output logic             pmicKeyN,
  output logic             pmicRstN,
  output logic             done,
  output logic             ok,
  output logic             coldReq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (stb.cntClear) begin
      cntVal <= '0;
    end else if (stb.cntInc) begin
      cntVal <= cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmicKeyN <= 1'b1;
      pmicRstN <= 1'b1;
    end else if (stb.releaseAll) begin
      pmicKeyN <= 1'b1;
      pmicRstN <= 1'b1;
    end else begin
      if (stb.driveKey) pmicKeyN <= 1'b0;
      if (stb.driveRst) pmicRstN <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      ok      <= 1'b0;
      coldReq <= 1'b0;
    end else begin
      done    <= stb.finish;
      coldReq <= stb.coldReq;
      if (stb.finish) ok <= stb.finishOk;
    end
  end

endmodule

// File: rtl/pmic_seq.sv
module pmic_seq
  import pmic_seq_pkg::*;
#(
  parameter int RESP_TICKS = 350,
  parameter int PULSE_TICKS = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cpuPwrGoodIn,
  input  logic       cpuRstSeenIn,
  input  logic       rstLineSenseIn,
  output logic       pmicKeyN,
  output logic       pmicRstN,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic       coldReq
);

  localparam int MAX_TICKS = (RESP_TICKS > PULSE_TICKS) ? RESP_TICKS : PULSE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [2:0]       syncVec;
  logic [CNT_W-1:0] cntVal;
  strobe_t          stb;

  // bit 2: reset-line readback (idles high), bit 1: reset seen, bit 0: power good
  pmic_seq_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({rstLineSenseIn, cpuRstSeenIn, cpuPwrGoodIn}),
    .syncOut(syncVec)
  );

  pmic_seq_ctrl #(
    .RESP_TICKS (RESP_TICKS),
    .PULSE_TICKS(PULSE_TICKS),
    .CNT_W      (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .cmdValid  (cmdValid),
    .cmdOp     (opCode_t'(cmdOp)),
    .pwrGoodS  (syncVec[0]),
    .rstSeenS  (syncVec[1]),
    .lineSenseS(syncVec[2]),
    .cntVal    (cntVal),
    .stb       (stb),
    .busy      (busy)
  );

  pmic_seq_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntVal  (cntVal),
    .pmicKeyN(pmicKeyN),
    .pmicRstN(pmicRstN),
    .done    (done),
    .ok      (ok),
    .coldReq (coldReq)
  );

endmodule

// File: rtl/pmic_seq_chk.sv
module pmic_seq_chk (
  input logic clk,
  input logic rstN,
  input logic pmicKeyN,
  input logic pmicRstN,
  input logic busy,
  input logic done,
  input logic ok,
  input logic coldReq
);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R8

  AST_LINES_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pmicKeyN && pmicRstN));  // R5

  AST_KEY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !pmicKeyN |-> busy);  // R3

  AST_RST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !pmicRstN |-> busy);  // R6

  AST_COLD_WITH_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    coldReq |-> (done && !ok));  // R7

  AST_COLD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    coldReq |=> !coldReq);  // R7

endmodule

bind pmic_seq pmic_seq_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .pmicKeyN(pmicKeyN),
  .pmicRstN(pmicRstN),
  .busy    (busy),
  .done    (done),
  .ok      (ok),
  .coldReq (coldReq)
);

// File: tb/pmic_seq_tb_top.sv
`timescale 1ns/1ps
module pmic_seq_tb_top;

  localparam int RT = 12;
  localparam int PT = 5;
  localparam int TD = 10;  // clock cycles per tick

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic pwrGood = 1'b0;
  logic rstSeen = 1'b0;
  logic lineSense = 1'b1;
  logic pmicKeyN, pmicRstN, busy, done, ok, coldReq;

  always #2.5 clk = ~clk;

  pmic_seq #(.RESP_TICKS(RT), .PULSE_TICKS(PT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cpuPwrGoodIn(pwrGood), .cpuRstSeenIn(rstSeen), .rstLineSenseIn(lineSense),
    .pmicKeyN(pmicKeyN), .pmicRstN(pmicRstN), .busy(busy), .done(done),
    .ok(ok), .coldReq(coldReq)
  );

  // tick generator
  int tickCnt = 0;
  always @(posedge clk) tickCnt <= (!rstN || tickCnt == TD-1) ? 0 : tickCnt + 1;
  assign tickEn = (tickCnt == TD-1);

  // PMIC emulation
  bit startResp = 1'b0, stopResp = 1'b0, warmResp = 1'b0;
  bit presetReq = 1'b0, presetVal = 1'b0;
  int onCnt = 0, offCnt = 0, wCnt = 0;
  logic prevRstN = 1'b1;
  always @(posedge clk) begin
    onCnt  <= (!pmicKeyN && pmicRstN)  ? onCnt + 1 : 0;
    offCnt <= (!pmicKeyN && !pmicRstN) ? offCnt + 1 : 0;
    if (presetReq) pwrGood <= presetVal;
    else if (startResp && onCnt == 25) pwrGood <= 1'b1;
    else if (stopResp && offCnt == 25) pwrGood <= 1'b0;
    prevRstN <= pmicRstN;
    if (warmResp && pmicKeyN && !prevRstN && pmicRstN) wCnt <= 1;
    else if (wCnt != 0 && wCnt < 10) wCnt <= wCnt + 1;
    else wCnt <= 0;
    rstSeen <= (wCnt >= 5 && wCnt < 9);
  end

  // counters and check helper
  int checks = 0, errors = 0;
  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    bit ok;
    bit cold;
    bit align;
    string req;
  } exp_t;
  exp_t sbQ[$];
  exp_t monItem;

  int keyLowTotal = 0, rstLowTotal = 0, rstRun = 0, lastRstRun = 0;
  int doneCount = 0, coldCount = 0;
  logic prevTick = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        doneCount++;
        if (sbQ.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          monItem = sbQ.pop_front();
          chk(ok == monItem.ok, monItem.req, "ok at done", ok, monItem.ok);
          chk(coldReq == monItem.cold, "R7", "coldReq at done", coldReq, monItem.cold);
          if (monItem.align) chk(prevTick == 1'b1, "R5", "done after tick", prevTick, 1);
        end
      end
      if (coldReq) coldCount++;
      if (!pmicKeyN) keyLowTotal++;
      if (!pmicRstN) begin
        rstLowTotal++;
        rstRun++;
      end else if (rstRun != 0) begin
        lastRstRun = rstRun;
        rstRun = 0;
      end
    end
    prevTick = tickEn;
  end

  task automatic presetPwrGood(input bit v);
    @(negedge clk);
    presetVal = v;
    presetReq = 1'b1;
    @(negedge clk);
    presetReq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic issueCmd(input logic [1:0] op, input bit expOk, input bit expCold,
                          input bit align, input string req);
    exp_t item;
    @(negedge clk);
    while (busy) @(negedge clk);
    item.ok = expOk; item.cold = expCold; item.align = align; item.req = req;
    sbQ.push_back(item);
    cmdValid = 1'b1;
    cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = 2'b00;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || sbQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    int k0, r0, d0, c0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(pmicKeyN == 1'b1 && pmicRstN == 1'b1, "R1", "lines high in reset", {pmicKeyN, pmicRstN}, 3);
    chk(busy == 0 && done == 0 && ok == 0 && coldReq == 0, "R1", "status low in reset",
        {busy, done, ok, coldReq}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R5: start, PMIC responds
    startResp = 1'b1;
    issueCmd(2'b01, 1'b1, 1'b0, 1'b1, "R5");
    repeat (3) @(negedge clk);
    chk(pmicKeyN == 0 && pmicRstN == 1, "R3", "start line levels", {pmicKeyN, pmicRstN}, 1);
    waitIdle();

    // R2: start while already on
    k0 = keyLowTotal; r0 = rstLowTotal;
    issueCmd(2'b01, 1'b1, 1'b0, 1'b0, "R2");
    waitIdle();
    chk(keyLowTotal == k0 && rstLowTotal == r0, "R2", "no line while on", keyLowTotal - k0, 0);

    // R3/R5: stop, PMIC responds
    stopResp = 1'b1;
    issueCmd(2'b10, 1'b1, 1'b0, 1'b1, "R5");
    repeat (3) @(negedge clk);
    chk(pmicKeyN == 0 && pmicRstN == 0, "R3", "stop line levels", {pmicKeyN, pmicRstN}, 0);
    waitIdle();

    // R2: stop while already off
    k0 = keyLowTotal; r0 = rstLowTotal;
    issueCmd(2'b10, 1'b1, 1'b0, 1'b0, "R2");
    waitIdle();
    chk(keyLowTotal == k0 && rstLowTotal == r0, "R2", "no line while off", rstLowTotal - r0, 0);

    // R5: start timeout
    startResp = 1'b0;
    k0 = keyLowTotal;
    issueCmd(2'b01, 1'b0, 1'b0, 1'b1, "R5");
    waitIdle();
    chk((keyLowTotal - k0) >= (RT-1)*TD + 1 && (keyLowTotal - k0) <= RT*TD, "R5",
        "key low span on timeout", keyLowTotal - k0, RT*TD);

    // R4: reset line not pulled up
    lineSense = 1'b0;
    repeat (4) @(negedge clk);
    k0 = keyLowTotal; r0 = rstLowTotal;
    issueCmd(2'b01, 1'b0, 1'b0, 1'b0, "R4");
    waitIdle();
    presetPwrGood(1'b1);
    issueCmd(2'b10, 1'b0, 1'b0, 1'b0, "R4");
    waitIdle();
    chk(keyLowTotal == k0 && rstLowTotal == r0, "R4", "no line on abort", keyLowTotal - k0, 0);
    lineSense = 1'b1;
    presetPwrGood(1'b0);

    // R6/R7: warm reset acknowledged
    warmResp = 1'b1;
    k0 = keyLowTotal;
    issueCmd(2'b11, 1'b1, 1'b0, 1'b0, "R7");
    waitIdle();
    chk(lastRstRun == PT*TD, "R6", "warm pulse width", lastRstRun, PT*TD);
    chk(keyLowTotal == k0, "R6", "key untouched by warm", keyLowTotal - k0, 0);

    // R7: warm reset not acknowledged
    warmResp = 1'b0;
    c0 = coldCount;
    issueCmd(2'b11, 1'b0, 1'b1, 1'b0, "R7");
    waitIdle();
    chk(coldCount == c0 + 1, "R7", "one cold request", coldCount - c0, 1);
    chk(lastRstRun == PT*TD, "R6", "second warm pulse width", lastRstRun, PT*TD);

    // R8: command while busy is dropped, code 00 never accepted
    startResp = 1'b1;
    d0 = doneCount;
    issueCmd(2'b01, 1'b1, 1'b0, 1'b1, "R8");
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b10;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    waitIdle();
    repeat (5) @(negedge clk);
    chk(doneCount == d0 + 1, "R8", "dones for two requests", doneCount - d0, 1);
    cmdValid = 1'b1; cmdOp = 2'b00;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "no-op code not accepted", busy, 0);
    repeat (3) @(negedge clk);
    chk(doneCount == d0 + 1, "R8", "no done for no-op", doneCount - d0, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule